// File: doc/BRIEF.md
# Scatter/Gather DMA Address Generator

This block produces the bus address for every source transfer and every destination transfer inside one DMA block. A block start loads both addresses from their programmed start values. After that, each transfer strobe on a side moves that side's address by one transfer width, upward or downward, or leaves it in place when the side is programmed as fixed.

On top of the plain stepping, the source side can gather and the destination side can scatter. Each side counts its own transfers. When the programmed count is reached, that transfer moves the address by a programmed increment times the transfer width in bytes, in the side's direction, and the count starts again. Burst formation, bus handshakes and block sequencing belong to the surrounding channel logic. That logic drives the strobes and reads the two addresses.

Top module: `sgAddrGen`

## Requirements
- R1: After reset, with no block start yet, srcAddr and dstAddr are both 0.
- R2: A cycle with blockStart high loads srcAddr from srcStartAddr and dstAddr from dstStartAddr on the next edge. blockStart wins over any transfer strobe in the same cycle.
- R3: On a transfer that is not a boundary, the address of that side moves by the transfer width in bytes. Mode code 0 adds the width and mode code 1 subtracts it. Arithmetic wraps modulo 2^ADDR_W.
- R4: Width code c gives 2^c bytes for c = 0, 1, 2. Any code from 3 to 7 is treated as 4 bytes.
- R5: Mode code 2 or 3 means fixed. A fixed side's address never changes on a transfer, and it takes no boundary jumps.
- R6: When gatherCount = N > 0, every Nth source transfer counted from block start or from the previous gather boundary is a gather boundary. On that transfer the source address moves by gatherInc times the width in bytes, in the side's direction, instead of the normal step. gatherCount = 0 disables gather.
- R7: When scatterEn = 1 and scatterCount = N > 0, the destination side behaves like R6, using scatterCount and scatterInc.
- R8: With scatterEn = 0, or with the destination in fixed mode, there are no scatter boundaries, whatever scatterCount holds.
- R9: A block start restarts both boundary counts. Transfers counted in the previous block do not carry over.
- R10: In a cycle with no strobe and no block start on a side, that side's address holds.
- R11: The two sides are independent. A source strobe never changes dstAddr, and a destination strobe never changes srcAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| blockStart | input | 1 | Load start addresses and restart the boundary counts |
| srcStartAddr | input | ADDR_W | Source start address |
| dstStartAddr | input | ADDR_W | Destination start address |
| srcWidthCode | input | 3 | Source transfer width code |
| dstWidthCode | input | 3 | Destination transfer width code |
| srcIncMode | input | 2 | Source mode: 0 up, 1 down, 2/3 fixed |
| dstIncMode | input | 2 | Destination mode: 0 up, 1 down, 2/3 fixed |
| gatherCount | input | CNT_W | Source transfers per gather boundary (0 = off) |
| scatterCount | input | CNT_W | Destination transfers per scatter boundary (0 = off) |
| gatherInc | input | INC_W | Gather jump, in transfer widths |
| scatterInc | input | INC_W | Scatter jump, in transfer widths |
| scatterEn | input | 1 | Scatter enable |
| srcXfer | input | 1 | One source transfer completes |
| dstXfer | input | 1 | One destination transfer completes |
| srcAddr | output | ADDR_W | Current source address |
| dstAddr | output | ADDR_W | Current destination address |

## Verification
The bench builds the block with ADDR_W = 12, CNT_W = 3 and INC_W = 3. With these values the sweep covers every mode, every width class including an out-of-range code, counts 0 to 3 and several jump sizes on both sides, each with the scatter enable on and off. The 12-bit addresses make downward runs from low start values wrap within a few transfers. The short counts put several boundaries, a mid-block restart, and strobe patterns that pause each side inside a single block of about a dozen cycles.

// File: rtl/sgAddrPkg.sv
package sgAddrPkg;

  typedef enum logic [1:0] {
    MODE_UP    = 2'b00,
    MODE_DOWN  = 2'b01,
    MODE_FIXED = 2'b10
  } incMode_e;

  // Strobes from control to datapath, one set per side
  typedef struct packed {
    logic load;   // take start address
    logic move;   // a non-fixed transfer happens
    logic jump;   // the move is a boundary jump
    logic down;   // direction of the move
  } sgStrobe_t;

  function automatic logic [2:0] widthBytes(input logic [2:0] code);
    case (code)
      3'd0:    widthBytes = 3'd1;
      3'd1:    widthBytes = 3'd2;
      default: widthBytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/sgAddrCtrl.sv
module sgAddrCtrl
  import sgAddrPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  blockStart,
  input  logic [1:0]            xfer,
  input  logic [1:0][CNT_W-1:0] count,
  input  logic [1:0]            fixedMode,
  input  logic [1:0]            downMode,
  input  logic [1:0]            sideEn,
  output sgStrobe_t [1:0]       strobe
);

  for (genvar g = 0; g < 2; g++) begin : gSide
    logic [CNT_W-1:0] remain;
    logic             boundaryOn;
    logic             atBoundary;
    logic             stepNow;

    assign boundaryOn = sideEn[g] && !fixedMode[g] && (count[g] != '0);
    assign stepNow    = xfer[g] && !blockStart;
    assign atBoundary = boundaryOn && (remain == CNT_W'(1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        remain <= '0;
      end else if (blockStart) begin
        remain <= count[g];
      end else if (stepNow && !fixedMode[g]) begin
        if (atBoundary)         remain <= count[g];
        else if (remain != '0) remain <= remain - CNT_W'(1);
      end
    end

    always_comb begin
      strobe[g].load = blockStart;
      strobe[g].move = stepNow && !fixedMode[g];
      strobe[g].jump = stepNow && !fixedMode[g] && atBoundary;
      strobe[g].down = downMode[g];
    end
  end

endmodule

// File: rtl/sgAddrPath.sv
module sgAddrPath
  import sgAddrPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int INC_W  = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  sgStrobe_t [1:0]        strobe,
  input  logic [1:0][ADDR_W-1:0] startAddr,
  input  logic [1:0][2:0]        widthCode,
  input  logic [1:0][INC_W-1:0]  jumpInc,
  output logic [1:0][ADDR_W-1:0] addr
);

  localparam int PROD_W = INC_W + 3;

  for (genvar g = 0; g < 2; g++) begin : gSide
    logic [2:0]        bytes;
    logic [PROD_W-1:0] jumpAmt;
    logic [ADDR_W-1:0] delta;
    logic [ADDR_W-1:0] addrQ;

    always_comb begin
      bytes   = widthBytes(widthCode[g]);
      jumpAmt = PROD_W'(jumpInc[g]) * PROD_W'(bytes);
      delta   = strobe[g].jump ? ADDR_W'(jumpAmt) : ADDR_W'(bytes);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrQ <= '0;
      end else if (strobe[g].load) begin
        addrQ <= startAddr[g];
      end else if (strobe[g].move) begin
        addrQ <= strobe[g].down ? addrQ - delta : addrQ + delta;
      end
    end

    assign addr[g] = addrQ;
  end

endmodule

// File: rtl/sgAddrGen.sv
module sgAddrGen
  import sgAddrPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8,
  parameter int INC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              blockStart,
  input  logic [ADDR_W-1:0] srcStartAddr,
  input  logic [ADDR_W-1:0] dstStartAddr,
  input  logic [2:0]        srcWidthCode,
  input  logic [2:0]        dstWidthCode,
  input  logic [1:0]        srcIncMode,
  input  logic [1:0]        dstIncMode,
  input  logic [CNT_W-1:0]  gatherCount,
  input  logic [CNT_W-1:0]  scatterCount,
  input  logic [INC_W-1:0]  gatherInc,
  input  logic [INC_W-1:0]  scatterInc,
  input  logic              scatterEn,
  input  logic              srcXfer,
  input  logic              dstXfer,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr
);

  // index 0 = source (gather), index 1 = destination (scatter)
  sgStrobe_t [1:0]        strobe;
  logic [1:0][ADDR_W-1:0] addr;

  sgAddrCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .blockStart(blockStart),
    .xfer      ({dstXfer, srcXfer}),
    .count     ({scatterCount, gatherCount}),
    .fixedMode ({dstIncMode[1], srcIncMode[1]}),
    .downMode  ({dstIncMode == MODE_DOWN, srcIncMode == MODE_DOWN}),
    .sideEn    ({scatterEn, 1'b1}),
    .strobe    (strobe)
  );

  sgAddrPath #(.ADDR_W(ADDR_W), .INC_W(INC_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .startAddr({dstStartAddr, srcStartAddr}),
    .widthCode({dstWidthCode, srcWidthCode}),
    .jumpInc  ({scatterInc, gatherInc}),
    .addr     (addr)
  );

  assign srcAddr = addr[0];
  assign dstAddr = addr[1];

endmodule

// File: rtl/sgAddrGenChk.sv
module sgAddrGenChk
  import sgAddrPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8,
  parameter int INC_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              blockStart,
  input logic [ADDR_W-1:0] srcStartAddr,
  input logic [ADDR_W-1:0] dstStartAddr,
  input logic [2:0]        srcWidthCode,
  input logic [2:0]        dstWidthCode,
  input logic [1:0]        srcIncMode,
  input logic [1:0]        dstIncMode,
  input logic [CNT_W-1:0]  gatherCount,
  input logic [CNT_W-1:0]  scatterCount,
  input logic              scatterEn,
  input logic              srcXfer,
  input logic              dstXfer,
  input logic [ADDR_W-1:0] srcAddr,
  input logic [ADDR_W-1:0] dstAddr
);

  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rstN)
    blockStart |=> (srcAddr == $past(srcStartAddr)) && (dstAddr == $past(dstStartAddr))); // R2

  AST_SRC_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!blockStart && srcIncMode[1]) |=> $stable(srcAddr)); // R5

  AST_DST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!blockStart && dstIncMode[1]) |=> $stable(dstAddr)); // R5

  AST_SRC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!blockStart && !srcXfer) |=> $stable(srcAddr)); // R10

  AST_DST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!blockStart && !dstXfer) |=> $stable(dstAddr)); // R11

  AST_SRC_PLAIN_UP: assert property (@(posedge clk) disable iff (!rstN)
    (!blockStart && srcXfer && gatherCount == '0 && srcIncMode == MODE_UP)
      |=> srcAddr == $past(srcAddr) + ADDR_W'(widthBytes($past(srcWidthCode)))); // R3

  AST_DST_NO_SCATTER_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (!blockStart && dstXfer && !scatterEn && dstIncMode == MODE_DOWN)
      |=> dstAddr == $past(dstAddr) - ADDR_W'(widthBytes($past(dstWidthCode)))); // R8

endmodule

bind sgAddrGen sgAddrGenChk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .INC_W(INC_W)) u_chk (
  .clk(clk), .rstN(rstN), .blockStart(blockStart),
  .srcStartAddr(srcStartAddr), .dstStartAddr(dstStartAddr),
  .srcWidthCode(srcWidthCode), .dstWidthCode(dstWidthCode),
  .srcIncMode(srcIncMode), .dstIncMode(dstIncMode),
  .gatherCount(gatherCount), .scatterCount(scatterCount),
  .scatterEn(scatterEn), .srcXfer(srcXfer), .dstXfer(dstXfer),
  .srcAddr(srcAddr), .dstAddr(dstAddr)
);

// File: tb/sgAddrGen_bench.sv
module sgAddrGen_bench;

  localparam int AW = 12;
  localparam int CW = 3;
  localparam int IW = 3;
  localparam int MASK = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          blockStart = 1'b0;
  logic [AW-1:0] srcStartAddr = '0, dstStartAddr = '0;
  logic [2:0]    srcWidthCode = '0, dstWidthCode = '0;
  logic [1:0]    srcIncMode = '0, dstIncMode = '0;
  logic [CW-1:0] gatherCount = '0, scatterCount = '0;
  logic [IW-1:0] gatherInc = '0, scatterInc = '0;
  logic          scatterEn = 1'b0;
  logic          srcXfer = 1'b0, dstXfer = 1'b0;
  logic [AW-1:0] srcAddr, dstAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected state, index 0 source, index 1 destination
  int    expAddr [2];
  int    expCnt  [2];
  string expReq  [2];

  always #10 clk = ~clk;

  sgAddrGen #(.ADDR_W(AW), .CNT_W(CW), .INC_W(IW)) u_sgAddrGen (
    .clk(clk), .rstN(rstN), .blockStart(blockStart),
    .srcStartAddr(srcStartAddr), .dstStartAddr(dstStartAddr),
    .srcWidthCode(srcWidthCode), .dstWidthCode(dstWidthCode),
    .srcIncMode(srcIncMode), .dstIncMode(dstIncMode),
    .gatherCount(gatherCount), .scatterCount(scatterCount),
    .gatherInc(gatherInc), .scatterInc(scatterInc),
    .scatterEn(scatterEn), .srcXfer(srcXfer), .dstXfer(dstXfer),
    .srcAddr(srcAddr), .dstAddr(dstAddr)
  );

  function automatic int bytesOf(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  // Update the model for one side for the inputs now applied (R2..R11)
  task automatic modelSide(input int s, input bit start, input bit xf, input int startA,
                           input int code, input int mode, input int cnt, input int inc,
                           input bit en);
    int  bytes;
    bit  fixed;
    bit  on;
    int  delta;
    bytes = bytesOf(code);
    fixed = (mode >= 2);
    on    = en && !fixed && (cnt != 0);
    if (start) begin
      expAddr[s] = startA;
      expCnt[s]  = cnt;
      expReq[s]  = "R2";
    end else if (!xf) begin
      expReq[s] = (s == 0) ? "R10" : "R11";
    end else if (fixed) begin
      expReq[s] = "R5";
    end else begin
      if (on && expCnt[s] == 1) begin
        delta     = inc * bytes;
        expCnt[s] = cnt;
        expReq[s] = (s == 0) ? "R6" : "R7";
      end else begin
        delta = bytes;
        if (expCnt[s] != 0) expCnt[s]--;
        if (s == 1 && !en && cnt != 0) expReq[s] = "R8";
        else if (code >= 3)            expReq[s] = "R4";
        else                           expReq[s] = "R3";
      end
      expAddr[s] = (mode == 1) ? ((expAddr[s] - delta) & MASK)
                               : ((expAddr[s] + delta) & MASK);
    end
  endtask

  // Apply inputs at a falling edge, advance one rising edge, check at next falling edge
  task automatic step(input bit start, input bit sx, input bit dx, input string tagOverride);
    blockStart = start;
    srcXfer    = sx;
    dstXfer    = dx;
    modelSide(0, start, sx, srcStartAddr, srcWidthCode, srcIncMode, gatherCount, gatherInc, 1'b1);
    modelSide(1, start, dx, dstStartAddr, dstWidthCode, dstIncMode, scatterCount, scatterInc,
              scatterEn);
    @(posedge clk);
    @(negedge clk);
    check((tagOverride != "") ? tagOverride : expReq[0], srcAddr, expAddr[0]);
    check((tagOverride != "") ? tagOverride : expReq[1], dstAddr, expAddr[1]);
  endtask

  initial begin
    int idx;
    idx = 0;
    repeat (3) @(negedge clk);
    check("R1", srcAddr, 0);
    check("R1", dstAddr, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", srcAddr, 0);
    check("R1", dstAddr, 0);
    expAddr[0] = 0; expAddr[1] = 0; expCnt[0] = 0; expCnt[1] = 0;

    for (int mode = 0; mode < 3; mode++)
      for (int code = 0; code < 4; code++)
        for (int cnt = 0; cnt < 4; cnt++)
          for (int incSel = 0; incSel < 3; incSel++)
            for (int en = 0; en < 2; en++) begin
              idx++;
              srcIncMode   = 2'(mode);
              dstIncMode   = 2'((mode + 1) % 3);
              srcWidthCode = 3'(code);
              dstWidthCode = 3'((code == 3) ? 7 : (code + 1) % 3);
              gatherCount  = CW'(cnt);
              scatterCount = CW'((cnt + 2) % 4);
              gatherInc    = IW'((incSel == 0) ? 0 : (incSel == 1) ? 2 : 5);
              scatterInc   = IW'((incSel == 0) ? 7 : (incSel == 1) ? 1 : 3);
              scatterEn    = en[0];
              srcStartAddr = AW'(16 + idx * 7);
              dstStartAddr = AW'(4000 - idx * 11);
              // block start with both strobes high: start must win (R2)
              step(1'b1, 1'b1, 1'b1, "R2");
              for (int t = 0; t < 6; t++) step(1'b0, (t % 3) != 2, (t % 2) == 0, "");
              // restart mid-block: counts begin again (R9)
              srcStartAddr = AW'(8 + idx * 5);
              dstStartAddr = AW'(3 + idx * 13);
              step(1'b1, 1'b0, 1'b0, "R9");
              for (int t = 0; t < 6; t++) begin
                step(1'b0, 1'b1, 1'b1, "");
                if (t == 0 && cnt != 0 && mode < 2) begin
                  // first source transfer after restart: boundary only if count is 1
                  checks++;
                  if ((cnt == 1) != (expReq[0] == "R6")) begin
                    errors++;
                    $display("FAIL R9: restart count actual %s expected boundary=%0d",
                             expReq[0], cnt == 1);
                  end
                end
              end
            end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule